// File: doc/BRIEF.md
# Time-Multiplexed Long FIR Filter

This block filters a mono stream of signed 24-bit audio samples with a long FIR response. It uses one shared 24x18 multiplier. Every input strobe stores the new sample in a circular history buffer. A sequencer then walks all taps, one per clock. Each step reads one signed 18-bit coefficient and one delayed sample from on-chip memories and adds their product to a wide accumulator. When the multiply-accumulate pipeline has emptied, the block rounds and saturates the sum to 24 bits and presents it with a one-cycle valid pulse. At audio sample rates the clock leaves hundreds of cycles per sample, so a single multiplier serves 512 or 1024 taps.

Coefficients are loaded through a plain write port, which takes a tap index and a value. The sequencer has four states:

- **CLEAR**: after reset, writes zero into every history entry, one per cycle. It moves to IDLE when its sweep index reaches the last entry.
- **IDLE**: waits for a strobe. It moves to RUN when it accepts one.
- **RUN**: issues one tap read per cycle. It moves to DRAIN after the last tap has been issued.
- **DRAIN**: waits for the read and product registers to empty. It returns to IDLE in the cycle it emits the result.

A strobe that arrives in CLEAR, RUN or DRAIN is discarded and reported on a one-cycle overrun flag. TAPS must be a power of two.

Top module: `tdm_fir`

## Requirements
- R1: While reset is held, `out_valid`, `overrun` and `out_data` are all zero. After release the block spends exactly TAPS cycles zeroing the sample history. During those cycles strobes are rejected, and every later output behaves as if all earlier samples were zero.
- R2: A write with `coef_we` high stores `coef_wdata` as the coefficient of tap `coef_addr`. Tap 0 multiplies the newest sample. Tap k multiplies the sample accepted k strobes earlier.
- R3: Each result equals the sum over k = 0..TAPS-1 of c[k]·x[n-k]. Only the newest TAPS accepted samples take part, and older samples fall out of the window, including across the wrap of the history pointer.
- R4: Coefficients are two's-complement Q1.17 values. The full sum S is scaled to floor((S + 2^16) / 2^17), which rounds halves upward.
- R5: The scaled value is saturated to the range -8388608..8388607 before output.
- R6: `out_valid` rises exactly TAPS+3 clock edges after the edge that accepts a strobe and stays high for one cycle. `out_data` changes only in that cycle and holds its value otherwise.
- R7: A strobe sampled while the block is in CLEAR, RUN or DRAIN raises `overrun` for exactly the next cycle. That sample is never stored, and the computation in progress is unaffected.
- R8: A strobe is accepted in the cycle in which `out_valid` is high, with no overrun, so one sample can be processed every TAPS+4 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | New-sample strobe |
| smp_data | input | DW (24) | Signed input sample |
| coef_we | input | 1 | Coefficient write enable |
| coef_addr | input | log2(TAPS) | Tap index of the coefficient write |
| coef_wdata | input | CW (18) | Signed Q1.17 coefficient |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | DW (24) | Rounded, saturated filter output |
| overrun | output | 1 | Strobe rejected because the block was busy |

## Verification
The bench builds the filter with TAPS = 16 and the default 24-bit data and 18-bit coefficients. This makes every tap, the history wrap and the loss of the oldest sample reachable within a few dozen samples. It also lets a hand-built table check the rounding exactly. The short length makes the exact TAPS+3 latency and the back-to-back acceptance cheap to measure on every sample. Overrun strobes are placed both in the tap-issue phase and in the drain phase.

// File: rtl/fir_pkg.sv
package fir_pkg;
    typedef enum logic [1:0] {
        ST_CLEAR,
        ST_IDLE,
        ST_RUN,
        ST_DRAIN
    } fir_state_e;
endpackage

// File: rtl/fir_ram.sv
// Simple dual-port memory: one write port, one registered read port.
module fir_ram #(
    parameter int WIDTH = 24,
    parameter int DEPTH = 512,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        if (re) begin
            rdata <= mem[raddr];
        end
    end
endmodule

// File: rtl/fir_mac.sv
// Registered product followed by a wide accumulator.
module fir_mac #(
    parameter int DW   = 24,
    parameter int CW   = 18,
    parameter int ACCW = 51,
    localparam int PW  = DW + CW
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   in_vld,
    input  logic signed [DW-1:0]   smp,
    input  logic signed [CW-1:0]   coef,
    output logic signed [ACCW-1:0] acc,
    output logic                   pipe_busy
);
    logic signed [PW-1:0] prod_q;
    logic                 prod_vld_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prod_q     <= '0;
            prod_vld_q <= 1'b0;
            acc        <= '0;
        end else begin
            prod_vld_q <= in_vld;
            if (in_vld) begin
                prod_q <= PW'(smp) * PW'(coef);
            end
            if (clr) begin
                acc <= '0;
            end else if (prod_vld_q) begin
                acc <= acc + {{(ACCW-PW){prod_q[PW-1]}}, prod_q};
            end
        end
    end

    assign pipe_busy = prod_vld_q;
endmodule

// File: rtl/fir_outstage.sv
// Round half up at the binary point, then clamp to the signed output range.
module fir_outstage #(
    parameter int ACCW = 51,
    parameter int DW   = 24,
    parameter int FRAC = 17
) (
    input  logic signed [ACCW-1:0] acc,
    output logic        [DW-1:0]   y
);
    localparam logic signed [ACCW-1:0] HALF =
        {{(ACCW-FRAC){1'b0}}, 1'b1, {(FRAC-1){1'b0}}};
    localparam logic signed [ACCW-1:0] MAXV =
        {{(ACCW-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [ACCW-1:0] MINV =
        {{(ACCW-DW+1){1'b1}}, {(DW-1){1'b0}}};

    logic signed [ACCW-1:0] biased;
    logic signed [ACCW-1:0] scaled;

    always_comb begin
        biased = acc + HALF;
        scaled = biased >>> FRAC;
        if (scaled > MAXV) begin
            y = MAXV[DW-1:0];
        end else if (scaled < MINV) begin
            y = MINV[DW-1:0];
        end else begin
            y = scaled[DW-1:0];
        end
    end
endmodule

// File: rtl/tdm_fir.sv
module tdm_fir #(
    parameter int TAPS = 512,
    parameter int DW   = 24,
    parameter int CW   = 18,
    localparam int AW  = $clog2(TAPS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_valid,
    input  logic [DW-1:0] smp_data,
    input  logic          coef_we,
    input  logic [AW-1:0] coef_addr,
    input  logic [CW-1:0] coef_wdata,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output logic          overrun
);
    import fir_pkg::*;

    localparam int ACCW = DW + CW + AW;
    localparam int FRAC = CW - 1;
    localparam logic [AW-1:0] LAST = AW'(TAPS - 1);

    fir_state_e state_q, state_d;
    logic [AW-1:0] idx_q;      // sweep index in CLEAR, tap index in RUN
    logic [AW-1:0] wptr_q;     // next history slot to fill
    logic [AW-1:0] newest_q;   // slot of the sample being filtered
    logic          rd_vld_q;
    logic          accept;
    logic          idx_last;
    logic          drained;

    logic          hist_we;
    logic [AW-1:0] hist_waddr;
    logic [DW-1:0] hist_wdata;
    logic          tap_re;
    logic [DW-1:0] hist_rdata;
    logic [CW-1:0] coef_rdata;
    logic signed [ACCW-1:0] acc;
    logic          mac_busy;
    logic [DW-1:0] result;

    assign accept   = (state_q == ST_IDLE) && smp_valid;
    assign idx_last = (idx_q == LAST);
    assign drained  = !rd_vld_q && !mac_busy;
    assign tap_re   = (state_q == ST_RUN);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR: if (idx_last)  state_d = ST_IDLE;
            ST_IDLE:  if (smp_valid) state_d = ST_RUN;
            ST_RUN:   if (idx_last)  state_d = ST_DRAIN;
            ST_DRAIN: if (drained)   state_d = ST_IDLE;
        endcase
    end

    // State register and sequencing counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_CLEAR;
            idx_q    <= '0;
            wptr_q   <= '0;
            newest_q <= '0;
            rd_vld_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            rd_vld_q <= tap_re;
            if (accept) begin
                newest_q <= wptr_q;
                wptr_q   <= wptr_q + 1'b1;
                idx_q    <= '0;
            end else if (state_q == ST_CLEAR || state_q == ST_RUN) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // Output register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            overrun   <= 1'b0;
        end else begin
            out_valid <= (state_q == ST_DRAIN) && drained;
            overrun   <= smp_valid && (state_q != ST_IDLE);
            if ((state_q == ST_DRAIN) && drained) begin
                out_data <= result;
            end
        end
    end

    // History write: zero sweep after reset, otherwise the accepted sample
    assign hist_we    = (state_q == ST_CLEAR) || accept;
    assign hist_waddr = (state_q == ST_CLEAR) ? idx_q : wptr_q;
    assign hist_wdata = (state_q == ST_CLEAR) ? '0 : smp_data;

    fir_ram #(.WIDTH(DW), .DEPTH(TAPS)) i_hist (
        .clk   (clk),
        .we    (hist_we),
        .waddr (hist_waddr),
        .wdata (hist_wdata),
        .re    (tap_re),
        .raddr (newest_q - idx_q),
        .rdata (hist_rdata)
    );

    fir_ram #(.WIDTH(CW), .DEPTH(TAPS)) i_coef (
        .clk   (clk),
        .we    (coef_we),
        .waddr (coef_addr),
        .wdata (coef_wdata),
        .re    (tap_re),
        .raddr (idx_q),
        .rdata (coef_rdata)
    );

    fir_mac #(.DW(DW), .CW(CW), .ACCW(ACCW)) i_mac (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (accept),
        .in_vld    (rd_vld_q),
        .smp       ($signed(hist_rdata)),
        .coef      ($signed(coef_rdata)),
        .acc       (acc),
        .pipe_busy (mac_busy)
    );

    fir_outstage #(.ACCW(ACCW), .DW(DW), .FRAC(FRAC)) i_out (
        .acc (acc),
        .y   (result)
    );
endmodule

// File: rtl/tdm_fir_chk.sv
module tdm_fir_chk #(
    parameter int TAPS = 512,
    parameter int DW   = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          smp_valid,
    input logic          busy,
    input logic          out_valid,
    input logic [DW-1:0] out_data,
    input logic          overrun
);
    int unsigned lat_q;

    // Counts edges since the last accepted strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= 0;
        end else if (smp_valid && !busy) begin
            lat_q <= 1;
        end else if (out_valid) begin
            lat_q <= 0;
        end else if (lat_q != 0) begin
            lat_q <= lat_q + 1;
        end
    end

    p_out_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    p_out_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_data));

    p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (lat_q == TAPS + 4));

    p_overrun_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && busy) |=> overrun);

    p_overrun_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> ($past(smp_valid) && $past(busy)));

    p_accept_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !busy) |=> !overrun);
endmodule

bind tdm_fir tdm_fir_chk #(.TAPS(TAPS), .DW(DW)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .busy      (state_q != fir_pkg::ST_IDLE),
    .out_valid (out_valid),
    .out_data  (out_data),
    .overrun   (overrun)
);

// File: tb/test_tdm_fir.sv
module test_tdm_fir;
    localparam int TAPS = 16;
    localparam int DW   = 24;
    localparam int CW   = 18;
    localparam int AW   = $clog2(TAPS);
    localparam int LAT  = TAPS + 3;

    // {input sample, expected output} with c[0] = c[1] = 0.5
    localparam int VEC [8][2] = '{
        '{100, 50}, '{201, 151}, '{-300, -49}, '{-1, -150},
        '{8388607, 4194303}, '{8388607, 8388607},
        '{-8388608, 0}, '{7, -4194300}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          smp_valid = 1'b0;
    logic [DW-1:0] smp_data = '0;
    logic          coef_we = 1'b0;
    logic [AW-1:0] coef_addr = '0;
    logic [CW-1:0] coef_wdata = '0;
    logic          out_valid;
    logic [DW-1:0] out_data;
    logic          overrun;

    int n_chk = 0;
    int n_fail = 0;
    int coef_m [TAPS];
    int hist_m [TAPS];
    int mp = 0;

    always #4 clk = ~clk;

    tdm_fir #(.TAPS(TAPS), .DW(DW), .CW(CW)) i_tdm_fir (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_valid  (smp_valid),
        .smp_data   (smp_data),
        .coef_we    (coef_we),
        .coef_addr  (coef_addr),
        .coef_wdata (coef_wdata),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .overrun    (overrun)
    );

    task automatic chk(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    function automatic int model_y();
        longint s = 0;
        longint r;
        for (int k = 0; k < TAPS; k++) begin
            s += longint'(coef_m[k]) * longint'(hist_m[(mp - k) & (TAPS - 1)]);
        end
        r = (s + 64'sd65536) >>> 17;
        if (r > 8388607) r = 8388607;
        if (r < -8388608) r = -8388608;
        return int'(r);
    endfunction

    function automatic int unsigned nxt(input int unsigned s);
        int unsigned v = s;
        v ^= v << 13;
        v ^= v >> 17;
        v ^= v << 5;
        return v;
    endfunction

    // Writes all coefficients from coef_m; called and returns at a falling edge
    task automatic load_coefs();
        for (int k = 0; k < TAPS; k++) begin
            coef_we    = 1'b1;
            coef_addr  = AW'(k);
            coef_wdata = CW'(coef_m[k]);
            @(posedge clk);
            @(negedge clk);
        end
        coef_we = 1'b0;
    endtask

    // Sends one sample at a falling edge; optionally injects a second strobe
    // inj_at edges later. Returns at the falling edge where out_valid is seen.
    task automatic run_sample(input int val, input int inj_at,
                              output int y, output int lat);
        smp_valid = 1'b1;
        smp_data  = DW'(val);
        mp = (mp + 1) & (TAPS - 1);
        hist_m[mp] = val;
        @(posedge clk);
        @(negedge clk);
        smp_valid = 1'b0;
        chk("R8 accepted without overrun", int'(overrun), 0);
        lat = 0;
        y = 0;
        while (lat < 4 * TAPS) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (inj_at != 0 && lat == inj_at + 1) begin
                chk("R7 overrun pulse on busy strobe", int'(overrun), 1);
                smp_valid = 1'b0;
            end
            if (inj_at != 0 && lat == inj_at) begin
                smp_valid = 1'b1;
                smp_data  = 24'h7FFFFF;
            end
            if (out_valid) begin
                y = int'($signed(out_data));
                break;
            end
        end
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL R6: watchdog expired, got 0 expected 1 completion");
        report();
        $finish;
    end

    initial begin
        int y;
        int lat;
        int unsigned rs = 32'h1234_5678;

        for (int k = 0; k < TAPS; k++) begin
            coef_m[k] = 0;
            hist_m[k] = 0;
        end

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 out_valid in reset", int'(out_valid), 0);
        chk("R1 overrun in reset", int'(overrun), 0);
        chk("R1 out_data in reset", int'(out_data), 0);
        rst_n = 1'b1;

        // R1/R7: strobe during the history sweep is rejected
        @(negedge clk);
        @(negedge clk);
        smp_valid = 1'b1;
        smp_data  = DW'(5000);
        @(negedge clk);
        smp_valid = 1'b0;
        chk("R1 strobe rejected while clearing", int'(overrun), 1);
        @(negedge clk);
        chk("R7 overrun lasts one cycle", int'(overrun), 0);
        repeat (TAPS) @(negedge clk);
        chk("R1 no output after sweep", int'(out_valid), 0);

        // R3/R4: table walk, c[0] = c[1] = 0.5 (Q1.17 value 65536)
        coef_m[0] = 65536;
        coef_m[1] = 65536;
        load_coefs();
        foreach (VEC[i]) begin
            run_sample(VEC[i][0], 0, y, lat);
            chk("R4 rounded table result", y, VEC[i][1]);
            chk("R6 latency", lat, LAT);
        end

        // R2/R3: only the last tap is set; an impulse appears after TAPS-1 samples
        for (int k = 0; k < TAPS; k++) coef_m[k] = 0;
        coef_m[TAPS-1] = 65536;
        load_coefs();
        for (int i = 0; i <= TAPS; i++) begin
            run_sample((i == 0) ? 1000 : 0, 0, y, lat);
            if (i == TAPS - 1) begin
                chk("R2 last tap sees oldest sample", y, 500);
            end else if (i == TAPS) begin
                chk("R3 sample beyond window dropped", y, 0);
            end else begin
                chk("R3 impulse walk", y, model_y());
            end
        end

        // R5: saturation at both limits, c[0] = c[1] = 131071
        coef_m[TAPS-1] = 0;
        coef_m[0] = 131071;
        coef_m[1] = 131071;
        load_coefs();
        run_sample(8388607, 0, y, lat);
        chk("R5 near full scale", y, model_y());
        run_sample(8388607, 0, y, lat);
        chk("R5 positive clamp", y, 8388607);
        run_sample(-8388608, 0, y, lat);
        chk("R5 mixed", y, model_y());
        run_sample(-8388608, 0, y, lat);
        chk("R5 negative clamp", y, -8388608);

        // R3: mixed coefficients and samples, back to back (R8)
        for (int k = 0; k < TAPS; k++) begin
            rs = nxt(rs);
            coef_m[k] = int'($signed(rs[17:0])) >>> 3;
        end
        load_coefs();
        for (int i = 0; i < 24; i++) begin
            rs = nxt(rs);
            run_sample(int'($signed(rs[23:0])), 0, y, lat);
            chk("R3 mixed stream", y, model_y());
            chk("R8 back-to-back latency", lat, LAT);
        end

        // R7: strobes while issuing taps and while draining are discarded
        run_sample(123456, 4, y, lat);
        chk("R7 result unaffected (run)", y, model_y());
        chk("R7 latency unaffected (run)", lat, LAT);
        run_sample(-654321, TAPS + 1, y, lat);
        chk("R7 result unaffected (drain)", y, model_y());
        run_sample(777, 0, y, lat);
        chk("R7 discarded sample never stored", y, model_y());
        @(negedge clk);
        chk("R6 valid is one cycle", int'(out_valid), 0);

        report();
        $finish;
    end
endmodule